// File: doc/BRIEF.md
# Horizontal Microinstruction Execution Stage

This block executes one horizontal microinstruction per clock on a small accumulator machine. The machine has an 11-bit address register and program counter, and a 16-bit data register and accumulator. The 20-bit word carries three 3-bit operation fields. Each field has its own one-hot decoder. The decoder outputs are combined into register load enables, datapath multiplexer selects, an accumulator function code, and the read and write strobes of main memory.

A microsequencer outside the block supplies the word. The eleven low bits (condition select, branch type and next-address) belong to that sequencer. The block returns them unchanged and does not use them itself.

Main memory attaches through a plain synchronous port. The address always comes from the address register and the write data always comes from the data register. Read data may enter only the data register. Every register that one word loads changes on the same rising edge, and each new value is computed from the contents the registers held before that edge.

Top module: `ucode_exec`

## Requirements
- R1: The word splits into op field A in bits [19:17], op field B in [16:14], op field C in [13:11], and sequencer bits in [10:0]. The code 000 in a field does nothing. A word whose three op fields are all 000 leaves AR, PC, DR and AC unchanged.
- R2: While rst_n is low, AR, PC, DR and AC are all zero.
- R3: Field A transfers: 100 loads AC from DR, 101 loads AR from DR[10:0], and 110 loads AR from PC.
- R4: Field A arithmetic and store: 001 sets AC to AC+DR, 010 clears AC, and 011 increments AC. Code 111 raises mem_wr for that cycle, and memory at address AR then holds DR.
- R5: Field B logic: 001 sets AC to AC-DR, 010 sets AC to AC|DR, and 011 sets AC to AC&DR.
- R6: Field B loads DR: 100 loads DR from memory at address AR and raises mem_rd, with read data valid in the same cycle. 101 loads DR from AC, 110 increments DR, and 111 loads DR with PC zero-extended.
- R7: Field C on AC: 001 sets AC to AC^DR, 010 complements AC, 011 shifts AC left with a zero entering, and 100 shifts AC right logically.
- R8: Field C on PC: 101 increments PC and 110 loads PC from AR. Code 111 does nothing. PC changes under no other code.
- R9: Transfers within one word are simultaneous. Every destination receives a value computed from the register contents before the edge.
- R10: ac_clash is high in the same cycle whenever two or more fields select an AC operation. In that case the field A operation takes effect, or the field B operation when field A has none.
- R11: seq_bits always equals word bits [10:0], and those bits have no effect on any register.
- R12: mem_addr always equals AR and mem_wdata always equals DR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| uword | input | 20 | Microinstruction for the current cycle |
| mem_rdata | input | 16 | Memory read data for address mem_addr, valid in the same cycle |
| mem_addr | output | 11 | Memory address (AR) |
| mem_wdata | output | 16 | Memory write data (DR) |
| mem_rd | output | 1 | Read strobe, DR loads mem_rdata at the edge |
| mem_wr | output | 1 | Write strobe for one cycle |
| ar_q | output | 11 | Address register |
| pc_q | output | 11 | Program counter |
| dr_q | output | 16 | Data register |
| ac_q | output | 16 | Accumulator |
| ac_clash | output | 1 | Two or more fields target AC |
| seq_bits | output | 11 | Sequencer bits of uword, passed through |

## Verification
The hardest cases to reach from the ports are the words in which one register is both a source and a destination of the same edge. Examples are AR loading from PC while PC increments, and DR reading memory at the AR that the same word overwrites. Such a word only reveals an ordering error once the registers already hold distinct, non-zero values. The stimulus therefore first loads a memory word into DR and spreads it into AC, AR and PC. Only then does it issue the overlapping words and the AC clash combinations, with all three fields active together.

// File: rtl/ucx_pkg.sv
package ucx_pkg;
  localparam int FIELD_W = 3;
  localparam int SEQ_W   = 11;

  typedef enum logic [3:0] {
    ACOP_HOLD, ACOP_ADD, ACOP_CLR, ACOP_INC, ACOP_LDDR, ACOP_SUB,
    ACOP_OR, ACOP_AND, ACOP_XOR, ACOP_NOT, ACOP_SHL, ACOP_SHR
  } ac_op_e;

  typedef enum logic [2:0] {
    DROP_HOLD, DROP_MEM, DROP_AC, DROP_INC, DROP_PC
  } dr_op_e;

  typedef enum logic [1:0] {
    PCOP_HOLD, PCOP_INC, PCOP_AR
  } pc_op_e;
endpackage

// File: rtl/ucx_fdec.sv
module ucx_fdec #(
  parameter int FW = 3,
  localparam int NH = 1 << FW
) (
  input  logic [FW-1:0] code,
  output logic [NH-1:0] hot
);
  for (genvar i = 0; i < NH; i++) begin : g_line
    assign hot[i] = (code == FW'(i));
  end
endmodule

// File: rtl/ucx_ctl.sv
module ucx_ctl
  import ucx_pkg::*;
#(
  parameter int NH = 8
) (
  input  logic [NH-1:0] hot_a,
  input  logic [NH-1:0] hot_b,
  input  logic [NH-1:0] hot_c,
  output ac_op_e        ac_op,
  output dr_op_e        dr_op,
  output pc_op_e        pc_op,
  output logic          ar_ld,
  output logic          ar_sel_dr,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic          ac_clash,
  output logic [2:0]    f_idle
);
  logic a_hits_ac, b_hits_ac, c_hits_ac;
  ac_op_e op_a, op_b, op_c;

  // AR load enable is the OR of two field-A lines; line 5 steers the mux to DR
  assign ar_ld     = hot_a[5] | hot_a[6];
  assign ar_sel_dr = hot_a[5];
  assign mem_wr    = hot_a[7];
  assign mem_rd    = hot_b[4];

  assign a_hits_ac = hot_a[1] | hot_a[2] | hot_a[3] | hot_a[4];
  assign b_hits_ac = hot_b[1] | hot_b[2] | hot_b[3];
  assign c_hits_ac = hot_c[1] | hot_c[2] | hot_c[3] | hot_c[4];
  assign ac_clash  = (a_hits_ac & b_hits_ac) | (a_hits_ac & c_hits_ac) |
                     (b_hits_ac & c_hits_ac);

  assign f_idle = {hot_a[0], hot_b[0], hot_c[0] | hot_c[7]};

  always_comb begin
    op_a = ACOP_HOLD;
    if (hot_a[1]) op_a = ACOP_ADD;
    if (hot_a[2]) op_a = ACOP_CLR;
    if (hot_a[3]) op_a = ACOP_INC;
    if (hot_a[4]) op_a = ACOP_LDDR;
  end

  always_comb begin
    op_b = ACOP_HOLD;
    if (hot_b[1]) op_b = ACOP_SUB;
    if (hot_b[2]) op_b = ACOP_OR;
    if (hot_b[3]) op_b = ACOP_AND;
  end

  always_comb begin
    op_c = ACOP_HOLD;
    if (hot_c[1]) op_c = ACOP_XOR;
    if (hot_c[2]) op_c = ACOP_NOT;
    if (hot_c[3]) op_c = ACOP_SHL;
    if (hot_c[4]) op_c = ACOP_SHR;
  end

  // Field A outranks field B, which outranks field C, on the AC port
  always_comb begin
    if (a_hits_ac)      ac_op = op_a;
    else if (b_hits_ac) ac_op = op_b;
    else                ac_op = op_c;
  end

  always_comb begin
    dr_op = DROP_HOLD;
    if (hot_b[4]) dr_op = DROP_MEM;
    if (hot_b[5]) dr_op = DROP_AC;
    if (hot_b[6]) dr_op = DROP_INC;
    if (hot_b[7]) dr_op = DROP_PC;
  end

  always_comb begin
    pc_op = PCOP_HOLD;
    if (hot_c[5]) pc_op = PCOP_INC;
    if (hot_c[6]) pc_op = PCOP_AR;
  end
endmodule

// File: rtl/ucx_dpath.sv
module ucx_dpath
  import ucx_pkg::*;
#(
  parameter int AW = 11,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  ac_op_e        ac_op,
  input  dr_op_e        dr_op,
  input  pc_op_e        pc_op,
  input  logic          ar_ld,
  input  logic          ar_sel_dr,
  input  logic [DW-1:0] mem_rdata,
  output logic [AW-1:0] ar_q,
  output logic [AW-1:0] pc_q,
  output logic [DW-1:0] dr_q,
  output logic [DW-1:0] ac_q
);
  localparam int PADW = DW - AW;

  logic [AW-1:0] ar_d, pc_d;
  logic [DW-1:0] dr_d, ac_d;

  function automatic logic [DW-1:0] acc_fn(ac_op_e op, logic [DW-1:0] a,
                                           logic [DW-1:0] d);
    case (op)
      ACOP_ADD:  return a + d;
      ACOP_CLR:  return '0;
      ACOP_INC:  return a + DW'(1);
      ACOP_LDDR: return d;
      ACOP_SUB:  return a - d;
      ACOP_OR:   return a | d;
      ACOP_AND:  return a & d;
      ACOP_XOR:  return a ^ d;
      ACOP_NOT:  return ~a;
      ACOP_SHL:  return {a[DW-2:0], 1'b0};
      ACOP_SHR:  return {1'b0, a[DW-1:1]};
      default:   return a;
    endcase
  endfunction

  always_comb begin
    ac_d = acc_fn(ac_op, ac_q, dr_q);
    ar_d = ar_q;
    if (ar_ld) ar_d = ar_sel_dr ? dr_q[AW-1:0] : pc_q;
    case (dr_op)
      DROP_MEM: dr_d = mem_rdata;
      DROP_AC:  dr_d = ac_q;
      DROP_INC: dr_d = dr_q + DW'(1);
      DROP_PC:  dr_d = {{PADW{1'b0}}, pc_q};
      default:  dr_d = dr_q;
    endcase
    case (pc_op)
      PCOP_INC: pc_d = pc_q + AW'(1);
      PCOP_AR:  pc_d = ar_q;
      default:  pc_d = pc_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ar_q <= '0;
      pc_q <= '0;
      dr_q <= '0;
      ac_q <= '0;
    end else begin
      ar_q <= ar_d;
      pc_q <= pc_d;
      dr_q <= dr_d;
      ac_q <= ac_d;
    end
  end

  // R9: AR takes the PC value from before the edge
  a_r9_ar_old_pc: assert property (@(posedge clk) disable iff (!rst_n)
    (ar_ld && !ar_sel_dr) |=> (ar_q == $past(pc_q)));

  // R6: a memory read lands in DR
  a_r6_dr_from_mem: assert property (@(posedge clk) disable iff (!rst_n)
    (dr_op == DROP_MEM) |=> (dr_q == $past(mem_rdata)));

  // R8: PC moves only when field C asks for it
  a_r8_pc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_op == PCOP_HOLD) |=> $stable(pc_q));
endmodule

// File: rtl/ucode_exec.sv
module ucode_exec
  import ucx_pkg::*;
#(
  parameter int AW = 11,
  parameter int DW = 16,
  parameter int FW = ucx_pkg::FIELD_W,
  localparam int NF = 3,
  localparam int NH = 1 << FW,
  localparam int UW = NF * FW + SEQ_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [UW-1:0] uword,
  input  logic [DW-1:0] mem_rdata,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [AW-1:0] ar_q,
  output logic [AW-1:0] pc_q,
  output logic [DW-1:0] dr_q,
  output logic [DW-1:0] ac_q,
  output logic          ac_clash,
  output logic [SEQ_W-1:0] seq_bits
);
  logic [NF-1:0][NH-1:0] hot;
  ac_op_e     ac_op;
  dr_op_e     dr_op;
  pc_op_e     pc_op;
  logic       ar_ld, ar_sel_dr;
  logic [2:0] f_idle;

  for (genvar k = 0; k < NF; k++) begin : g_dec
    ucx_fdec #(.FW(FW)) u_dec (
      .code (uword[UW-1-k*FW -: FW]),
      .hot  (hot[k])
    );
  end

  ucx_ctl #(.NH(NH)) u_ctl (
    .hot_a     (hot[0]),
    .hot_b     (hot[1]),
    .hot_c     (hot[2]),
    .ac_op     (ac_op),
    .dr_op     (dr_op),
    .pc_op     (pc_op),
    .ar_ld     (ar_ld),
    .ar_sel_dr (ar_sel_dr),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .ac_clash  (ac_clash),
    .f_idle    (f_idle)
  );

  ucx_dpath #(.AW(AW), .DW(DW)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .ac_op     (ac_op),
    .dr_op     (dr_op),
    .pc_op     (pc_op),
    .ar_ld     (ar_ld),
    .ar_sel_dr (ar_sel_dr),
    .mem_rdata (mem_rdata),
    .ar_q      (ar_q),
    .pc_q      (pc_q),
    .dr_q      (dr_q),
    .ac_q      (ac_q)
  );

  assign mem_addr  = ar_q;
  assign mem_wdata = dr_q;
  assign seq_bits  = uword[SEQ_W-1:0];

  // R1: an all-idle word leaves every register as it was
  a_r1_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (&f_idle) |=> ($stable(ar_q) && $stable(pc_q) && $stable(dr_q) && $stable(ac_q)));

  // R10: under a clash, a field-A clear wins
  a_r10_a_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (ac_clash && hot[0][2]) |=> (ac_q == '0));
endmodule

// File: tb/tb_ucode_exec.sv
module tb_ucode_exec;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [19:0] uword;
  logic [15:0] mem_rdata, mem_wdata, dr_q, ac_q;
  logic [10:0] mem_addr, ar_q, pc_q, seq_bits;
  logic        mem_rd, mem_wr, ac_clash;

  always #10 clk = ~clk;

  ucode_exec dut (
    .clk(clk), .rst_n(rst_n), .uword(uword), .mem_rdata(mem_rdata),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .ar_q(ar_q), .pc_q(pc_q), .dr_q(dr_q), .ac_q(ac_q),
    .ac_clash(ac_clash), .seq_bits(seq_bits)
  );

  logic [15:0] mem [0:2047];
  logic [15:0] em  [0:2047];
  always @(posedge clk) if (mem_wr) mem[mem_addr] <= mem_wdata;
  assign mem_rdata = mem[mem_addr];

  typedef struct {
    logic [10:0] ar, pc;
    logic [15:0] dr, ac;
    string       tag;
  } exp_t;
  exp_t sb[$];

  int nvec = 0, nbad = 0;
  logic [10:0] m_ar = '0, m_pc = '0;
  logic [15:0] m_dr = '0, m_ac = '0;

  task automatic check(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [19:0] mk(input logic [2:0] a, input logic [2:0] b,
                                     input logic [2:0] c, input logic [10:0] s);
    return {a, b, c, s};
  endfunction

  task automatic apply(input logic [19:0] w, input string tag);
    logic [2:0] fa, fb, fc;
    logic [15:0] nac, ndr;
    logic [10:0] nar, npc;
    int hits;
    exp_t e;
    @(negedge clk); #2;
    uword = w; #1;
    fa = w[19:17]; fb = w[16:14]; fc = w[13:11];
    hits = int'(fa inside {3'd1, 3'd2, 3'd3, 3'd4}) + int'(fb inside {3'd1, 3'd2, 3'd3})
         + int'(fc inside {3'd1, 3'd2, 3'd3, 3'd4});
    check({tag, " R10"}, "ac_clash", 16'(ac_clash), 16'(hits > 1));
    check({tag, " R11"}, "seq_bits", 16'(seq_bits), 16'(w[10:0]));
    check({tag, " R12"}, "mem_addr", 16'(mem_addr), 16'(m_ar));
    check({tag, " R12"}, "mem_wdata", mem_wdata, m_dr);
    check({tag, " R4/R6"}, "strobes", 16'({mem_wr, mem_rd}), 16'({fa == 3'd7, fb == 3'd4}));
    nac = m_ac;
    case (fc)
      3'd1: nac = m_ac ^ m_dr;
      3'd2: nac = ~m_ac;
      3'd3: nac = m_ac << 1;
      3'd4: nac = m_ac >> 1;
      default: ;
    endcase
    case (fb)
      3'd1: nac = m_ac - m_dr;
      3'd2: nac = m_ac | m_dr;
      3'd3: nac = m_ac & m_dr;
      default: ;
    endcase
    case (fa)
      3'd1: nac = m_ac + m_dr;
      3'd2: nac = 16'h0000;
      3'd3: nac = m_ac + 16'd1;
      3'd4: nac = m_dr;
      default: ;
    endcase
    nar = (fa == 3'd5) ? m_dr[10:0] : (fa == 3'd6) ? m_pc : m_ar;
    npc = (fc == 3'd5) ? m_pc + 11'd1 : (fc == 3'd6) ? m_ar : m_pc;
    case (fb)
      3'd4: ndr = em[m_ar];
      3'd5: ndr = m_ac;
      3'd6: ndr = m_dr + 16'd1;
      3'd7: ndr = {5'd0, m_pc};
      default: ndr = m_dr;
    endcase
    if (fa == 3'd7) em[m_ar] = m_dr;
    m_ar = nar; m_pc = npc; m_dr = ndr; m_ac = nac;
    e.ar = nar; e.pc = npc; e.dr = ndr; e.ac = nac; e.tag = tag;
    sb.push_back(e);
  endtask

  initial begin
    forever begin
      @(negedge clk); #1;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        check(e.tag, "AR", 16'(ar_q), 16'(e.ar));
        check(e.tag, "PC", 16'(pc_q), 16'(e.pc));
        check(e.tag, "DR", dr_q, e.dr);
        check(e.tag, "AC", ac_q, e.ac);
      end
    end
  end

  initial begin
    #2000000;
    nbad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 2048; i++) begin
      mem[i] = 16'(i * 16'h3b1 + 16'h11);
      em[i]  = mem[i];
    end
    mem[0] = 16'h8A5C; em[0] = 16'h8A5C;
    rst_n = 1'b0;
    uword = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    check("R2 reset", "AR", 16'(ar_q), 16'h0);
    check("R2 reset", "PC", 16'(pc_q), 16'h0);
    check("R2 reset", "DR", dr_q, 16'h0);
    check("R2 reset", "AC", ac_q, 16'h0);
    rst_n = 1'b1;

    apply(mk(0, 0, 0, 11'h5A3), "R1 R11 idle word");
    apply(mk(0, 4, 0, 11'h000), "R6 read mem");
    apply(mk(4, 0, 0, 11'h7FF), "R3 ac from dr");
    apply(mk(5, 0, 0, 11'h000), "R3 ar from dr");
    apply(mk(0, 0, 6, 11'h000), "R8 pc from ar");
    apply(mk(6, 0, 5, 11'h000), "R9 ar old pc");
    apply(mk(0, 5, 5, 11'h2AA), "R6 dr from ac");
    apply(mk(1, 0, 0, 11'h000), "R4 add");
    apply(mk(0, 1, 0, 11'h000), "R5 sub");
    apply(mk(0, 2, 0, 11'h000), "R5 or");
    apply(mk(0, 3, 0, 11'h000), "R5 and");
    apply(mk(3, 0, 0, 11'h000), "R4 inc");
    apply(mk(0, 0, 1, 11'h000), "R7 xor");
    apply(mk(0, 0, 2, 11'h000), "R7 not");
    apply(mk(0, 0, 3, 11'h000), "R7 shl");
    apply(mk(0, 0, 4, 11'h000), "R7 shr");
    apply(mk(0, 6, 0, 11'h000), "R6 dr inc");
    apply(mk(0, 7, 0, 11'h000), "R6 dr from pc");
    apply(mk(7, 0, 0, 11'h000), "R4 store");
    apply(mk(0, 4, 0, 11'h000), "R4 readback");
    apply(mk(2, 1, 0, 11'h000), "R10 clear wins");
    apply(mk(0, 2, 4, 11'h000), "R10 or wins");
    apply(mk(4, 3, 2, 11'h000), "R10 triple");
    apply(mk(0, 0, 7, 11'h155), "R8 idle code");
    apply(mk(6, 4, 5, 11'h000), "R9 read and ar move");
    apply(mk(5, 0, 6, 11'h000), "R9 ar pc swap");
    apply(mk(4, 5, 0, 11'h000), "R9 ac dr swap");
    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule